// File: doc/BRIEF.md
# Pixel Output Demux Formatter

This block sits between converter logic that delivers one 24-bit RGB pixel (three 8-bit components) per pixel-clock cycle and a pair of 24-bit output ports, A and B. In half-rate mode it gathers pixels in pairs and presents both at once: the earlier pixel on A and the later one on B, with one output-valid strobe per pair. That strobe serves as the clock enable for the half-rate output domain. In full-rate mode every pixel goes to port A and B is parked at a constant level.

A small control register is loaded through a parallel write port. It sets pad drive enable, rate mode, data inversion, a forced-level override, and the polarity and source of the clamp signal. The priority is fixed. Pad enable off removes drive from the pins. Force comes next and replaces all data with a constant. Otherwise data passes through, inverted or unchanged. A line-start strobe realigns the pixel pairing and starts the internal clamp pulse. The input side has no back-pressure: a pixel is taken on every cycle that `in_valid` is high. The downstream side must accept every cycle on which `out_valid` is high.

Top module: `pix_fmt`

## Requirements
- R1: Control word bits are: bit0 pad enable, bit1 full-rate, bit2 pass (1 = no inversion), bit3 force, bit4 clamp negative, bit5 clamp external. After reset the word is 6'b000100: pads off, half-rate, pass-through, no force, internal positive clamp. Port data registers, `out_valid` and the clamp counter are also cleared.
- R2: `a_oe` and `b_oe` equal the pad-enable bit. Force and data settings do not change them.
- R3: In half-rate mode, the first pixel of a pair is held. When the second arrives, A shows the first and B the second, both from the next cycle. `out_valid` pulses for one cycle per completed pair and is never high on two cycles in a row.
- R4: A `line_start` strobe discards any half-completed pair. A pixel that arrives with the strobe becomes the first of a new pair.
- R5: In full-rate mode, each accepted pixel appears on A the next cycle with `out_valid` high. B is all ones when pass is 1 and all zeros when pass is 0.
- R6: With pass at 0 and force at 0, A (and B in half-rate mode) carry the bitwise inverse of the pixel data.
- R7: With force at 1, every bit of A and B is driven to the pass bit's level, whatever the data or mode.
- R8: The internal clamp is high for exactly CLAMP_LEN cycles, starting the cycle after `line_start`. A new strobe restarts the count.
- R9: With clamp negative at 1, `clamp_out` is the complement of the selected clamp source.
- R10: With clamp external at 1, the source is the `ext_clamp` input, passed through combinationally.
- R11: A write changes the outputs from the cycle after the write edge. A write that changes the full-rate bit discards any half-completed pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 6 | Control word value |
| in_valid | input | 1 | Pixel present this cycle |
| in_pix | input | 24 | Input pixel, three components |
| line_start | input | 1 | Start of a new line |
| ext_clamp | input | 1 | External clamp source |
| out_valid | output | 1 | Output pair/pixel strobe (half-rate clock enable) |
| a_data | output | 24 | Port A data |
| a_oe | output | 1 | Port A pad drive enable |
| b_data | output | 24 | Port B data |
| b_oe | output | 1 | Port B pad drive enable |
| clamp_out | output | 1 | Clamp signal after source select and polarity |

## Verification
The bench builds the block with 8-bit components, three per pixel, and CLAMP_LEN set to 5 instead of the default 16. With a pulse that short, the clamp's end, and a restart during the pulse, both fall within a few idle cycles of each scenario. The pixel widths keep the inversion and forced levels visible on every component. Odd-length lines, bare line-start strobes and mode flips in the middle of a pair all exercise the realignment of the pairing.

// File: rtl/pix_fmt_pkg.sv
package pix_fmt_pkg;

  // Control word, bit 0 is the LSB (pad enable)
  typedef struct packed {
    logic clamp_ext;
    logic clamp_neg;
    logic force_lvl;
    logic pass;
    logic full_rate;
    logic out_en;
  } fmt_cfg_t;

  localparam int CFG_W = $bits(fmt_cfg_t);

  localparam fmt_cfg_t CFG_RST = '{
    clamp_ext: 1'b0,
    clamp_neg: 1'b0,
    force_lvl: 1'b0,
    pass:      1'b1,
    full_rate: 1'b0,
    out_en:    1'b0
  };

endpackage

// File: rtl/pix_fmt_cfg.sv
module pix_fmt_cfg
  import pix_fmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output fmt_cfg_t         cfg,
  output logic             mode_flip
);

  fmt_cfg_t wr_cfg;

  assign wr_cfg    = fmt_cfg_t'(wdata);
  assign mode_flip = we && (wr_cfg.full_rate != cfg.full_rate);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_RST;
    end else if (we) begin
      cfg <= wr_cfg;
    end
  end

endmodule

// File: rtl/pix_fmt_pair.sv
module pix_fmt_pair #(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             full_rate,
  input  logic             line_start,
  input  logic             mode_flip,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pix,
  output logic [PIX_W-1:0] a_q,
  output logic [PIX_W-1:0] b_q,
  output logic             valid_q
);

  logic             second;   // next pixel completes a pair
  logic [PIX_W-1:0] held;
  logic             eff_second;

  // a line start makes the pixel arriving with it the first of a pair
  assign eff_second = second && !line_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      second  <= 1'b0;
      held    <= '0;
      a_q     <= '0;
      b_q     <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (in_valid) begin
        if (full_rate) begin
          a_q     <= in_pix;
          valid_q <= 1'b1;
          second  <= 1'b0;
        end else if (!eff_second) begin
          held   <= in_pix;
          second <= 1'b1;
        end else begin
          a_q     <= held;
          b_q     <= in_pix;
          valid_q <= 1'b1;
          second  <= 1'b0;
        end
      end else if (line_start) begin
        second <= 1'b0;
      end
      if (mode_flip) begin
        second <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pix_fmt_clamp.sv
module pix_fmt_clamp #(
  parameter int CLAMP_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic line_start,
  input  logic ext_clamp,
  input  logic use_ext,
  input  logic negate,
  output logic clamp_out
);

  localparam int CNT_W = $clog2(CLAMP_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CLAMP_LEN);

  logic [CNT_W-1:0] cnt;
  logic             pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (line_start) begin
      cnt <= CNT_LOAD;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign pulse     = (cnt != '0);
  assign clamp_out = (use_ext ? ext_clamp : pulse) ^ negate;

endmodule

// File: rtl/pix_fmt_drive.sv
module pix_fmt_drive
  import pix_fmt_pkg::*;
#(
  parameter int COMP_W = 8,
  parameter int NCOMP  = 3,
  localparam int PIX_W = COMP_W * NCOMP
) (
  input  fmt_cfg_t         cfg,
  input  logic [PIX_W-1:0] a_q,
  input  logic [PIX_W-1:0] b_q,
  output logic [PIX_W-1:0] a_data,
  output logic [PIX_W-1:0] b_data,
  output logic             a_oe,
  output logic             b_oe
);

  logic [COMP_W-1:0] fill;
  logic              b_park;

  assign fill   = {COMP_W{cfg.pass}};
  assign b_park = cfg.force_lvl || cfg.full_rate;
  assign a_oe   = cfg.out_en;
  assign b_oe   = cfg.out_en;

  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    logic [COMP_W-1:0] a_c;
    logic [COMP_W-1:0] b_c;
    assign a_c = a_q[c*COMP_W +: COMP_W];
    assign b_c = b_q[c*COMP_W +: COMP_W];
    assign a_data[c*COMP_W +: COMP_W] =
      cfg.force_lvl ? fill : (cfg.pass ? a_c : ~a_c);
    assign b_data[c*COMP_W +: COMP_W] =
      b_park ? fill : (cfg.pass ? b_c : ~b_c);
  end

endmodule

// File: rtl/pix_fmt.sv
module pix_fmt
  import pix_fmt_pkg::*;
#(
  parameter int COMP_W    = 8,
  parameter int NCOMP     = 3,
  parameter int CLAMP_LEN = 16,
  localparam int PIX_W    = COMP_W * NCOMP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             line_start,
  input  logic             ext_clamp,
  output logic             out_valid,
  output logic [PIX_W-1:0] a_data,
  output logic             a_oe,
  output logic [PIX_W-1:0] b_data,
  output logic             b_oe,
  output logic             clamp_out
);

  fmt_cfg_t         cfg_q;
  logic             mode_flip;
  logic [PIX_W-1:0] a_q;
  logic [PIX_W-1:0] b_q;

  pix_fmt_cfg u_cfg (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we),
    .wdata     (cfg_wdata),
    .cfg       (cfg_q),
    .mode_flip (mode_flip)
  );

  pix_fmt_pair #(.PIX_W(PIX_W)) u_pair (
    .clk        (clk),
    .rst        (rst),
    .full_rate  (cfg_q.full_rate),
    .line_start (line_start),
    .mode_flip  (mode_flip),
    .in_valid   (in_valid),
    .in_pix     (in_pix),
    .a_q        (a_q),
    .b_q        (b_q),
    .valid_q    (out_valid)
  );

  pix_fmt_clamp #(.CLAMP_LEN(CLAMP_LEN)) u_clamp (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .ext_clamp  (ext_clamp),
    .use_ext    (cfg_q.clamp_ext),
    .negate     (cfg_q.clamp_neg),
    .clamp_out  (clamp_out)
  );

  pix_fmt_drive #(.COMP_W(COMP_W), .NCOMP(NCOMP)) u_drive (
    .cfg    (cfg_q),
    .a_q    (a_q),
    .b_q    (b_q),
    .a_data (a_data),
    .b_data (b_data),
    .a_oe   (a_oe),
    .b_oe   (b_oe)
  );

endmodule

// File: rtl/pix_fmt_chk.sv
module pix_fmt_chk
  import pix_fmt_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic             in_valid,
  input logic             line_start,
  input logic             ext_clamp,
  input logic             out_valid,
  input logic [PIX_W-1:0] a_data,
  input logic             a_oe,
  input logic [PIX_W-1:0] b_data,
  input logic             b_oe,
  input logic             clamp_out,
  input fmt_cfg_t         cfg
);

  fmt_cfg_t wd;
  assign wd = fmt_cfg_t'(cfg_wdata);

  assert_reset_pads_off_R1: assert property (@(posedge clk)
    $past(rst) |-> (!a_oe && !b_oe && !out_valid));

  assert_write_oe_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (a_oe == $past(wd.out_en) && b_oe == $past(wd.out_en)));

  assert_half_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !cfg.full_rate && !cfg_we) |=> !out_valid);

  assert_full_valid_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg.full_rate && in_valid && !cfg_we) |=> out_valid);

  assert_full_park_low_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg.full_rate && !cfg.pass) |-> (b_data == '0));

  assert_full_park_high_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg.full_rate && cfg.pass) |-> (&b_data));

  assert_force_high_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && wd.force_lvl && wd.pass) |=> ((&a_data) && (&b_data)));

  assert_force_low_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && wd.force_lvl && !wd.pass) |=> (a_data == '0 && b_data == '0));

  assert_clamp_start_R8: assert property (@(posedge clk) disable iff (rst)
    (line_start && !cfg_we && !cfg.clamp_ext && !cfg.clamp_neg) |=> clamp_out);

  assert_clamp_ext_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg.clamp_ext && !cfg.clamp_neg) |-> (clamp_out == ext_clamp));

endmodule

bind pix_fmt pix_fmt_chk #(.PIX_W(PIX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_we     (cfg_we),
  .cfg_wdata  (cfg_wdata),
  .in_valid   (in_valid),
  .line_start (line_start),
  .ext_clamp  (ext_clamp),
  .out_valid  (out_valid),
  .a_data     (a_data),
  .a_oe       (a_oe),
  .b_data     (b_data),
  .b_oe       (b_oe),
  .clamp_out  (clamp_out),
  .cfg        (cfg_q)
);

// File: tb/pix_fmt_bench.sv
module pix_fmt_bench;

  localparam int COMP_W    = 8;
  localparam int NCOMP     = 3;
  localparam int CLAMP_LEN = 5;
  localparam int PIX_W     = COMP_W * NCOMP;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [5:0]       cfg_wdata = '0;
  logic             in_valid = 1'b0;
  logic [PIX_W-1:0] in_pix = '0;
  logic             line_start = 1'b0;
  logic             ext_clamp = 1'b0;
  logic             out_valid;
  logic [PIX_W-1:0] a_data;
  logic             a_oe;
  logic [PIX_W-1:0] b_data;
  logic             b_oe;
  logic             clamp_out;

  always #4 clk = ~clk;

  pix_fmt #(.COMP_W(COMP_W), .NCOMP(NCOMP), .CLAMP_LEN(CLAMP_LEN)) u_pix_fmt (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .in_valid   (in_valid),
    .in_pix     (in_pix),
    .line_start (line_start),
    .ext_clamp  (ext_clamp),
    .out_valid  (out_valid),
    .a_data     (a_data),
    .a_oe       (a_oe),
    .b_data     (b_data),
    .b_oe       (b_oe),
    .clamp_out  (clamp_out)
  );

  int    n_run  = 0;
  int    n_fail = 0;
  string cur_tag = "R1";
  int    pix_seq = 0;

  // behavioural reference state
  logic [5:0]       m_cfg;
  logic [PIX_W-1:0] pend[$];
  logic [PIX_W-1:0] m_a;
  logic [PIX_W-1:0] m_b;
  logic             m_valid;
  int               m_cnt;

  always @(posedge clk) begin
    if (rst) begin
      m_cfg   = 6'b000100;
      pend.delete();
      m_a     = '0;
      m_b     = '0;
      m_valid = 1'b0;
      m_cnt   = 0;
    end else begin
      m_valid = 1'b0;
      if (line_start) pend.delete();
      if (in_valid) begin
        if (m_cfg[1]) begin
          m_a     = in_pix;
          m_valid = 1'b1;
        end else begin
          pend.push_back(in_pix);
          if (pend.size() == 2) begin
            m_a     = pend[0];
            m_b     = pend[1];
            m_valid = 1'b1;
            pend.delete();
          end
        end
      end
      if (cfg_we) begin
        if (cfg_wdata[1] != m_cfg[1]) pend.delete();
        m_cfg = cfg_wdata;
      end
      if (line_start) m_cnt = CLAMP_LEN;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
    end
  end

  task automatic chk(string tag, string what, logic [PIX_W-1:0] act,
                     logic [PIX_W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare every cycle, 2 ns after the active edge
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      logic [PIX_W-1:0] fill;
      logic [PIX_W-1:0] ea;
      logic [PIX_W-1:0] eb;
      logic             ec;
      fill = {PIX_W{m_cfg[2]}};
      ea = m_cfg[3] ? fill : (m_cfg[2] ? m_a : ~m_a);
      eb = (m_cfg[3] || m_cfg[1]) ? fill : (m_cfg[2] ? m_b : ~m_b);
      ec = (m_cfg[5] ? ext_clamp : (m_cnt > 0)) ^ m_cfg[4];
      chk(cur_tag, "a_data", a_data, ea);
      chk(cur_tag, "b_data", b_data, eb);
      chk(cur_tag, "a_oe", PIX_W'(a_oe), PIX_W'(m_cfg[0]));
      chk(cur_tag, "b_oe", PIX_W'(b_oe), PIX_W'(m_cfg[0]));
      chk(cur_tag, "out_valid", PIX_W'(out_valid), PIX_W'(m_valid));
      chk(cur_tag, "clamp_out", PIX_W'(clamp_out), PIX_W'(ec));
    end
  end

  task automatic step(logic we, logic [5:0] wd, logic iv, logic ls, logic ep);
    @(negedge clk);
    cfg_we     = we;
    cfg_wdata  = wd;
    in_valid   = iv;
    line_start = ls;
    ext_clamp  = ep;
    if (iv) begin
      in_pix  = PIX_W'(24'h13A7C5 + pix_seq * 24'h0B1D29);
      pix_seq = pix_seq + 1;
    end
  endtask

  task automatic wr(logic [5:0] wd);
    step(1'b1, wd, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic line(int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b1, (i == 0), 1'b0);
  endtask

  bit done = 1'b0;

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cur_tag = "R1";  idle(3);
    // R1 reset pads off, pass-through, half-rate
    @(negedge clk);
    chk("R1", "reset a_oe", PIX_W'(a_oe), '0);
    chk("R1", "reset a_data", a_data, '0);

    cur_tag = "R2";  wr(6'b000101); idle(2);
    cur_tag = "R3";  line(8); idle(2);
    cur_tag = "R4";  line(5); line(4);
    step(1'b0, '0, 1'b1, 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b1, 1'b0);
    line(1); step(1'b0, '0, 1'b1, 1'b0, 1'b0); idle(2);
    cur_tag = "R6";  wr(6'b000001); line(6); idle(1);
    cur_tag = "R5";  wr(6'b000011); line(5);
    wr(6'b000111); line(2); idle(1); line(3); idle(1);
    cur_tag = "R11"; wr(6'b000101); line(3);
    wr(6'b000111); wr(6'b000101);
    line(1); step(1'b0, '0, 1'b1, 1'b0, 1'b0);
    wr(6'b000100); wr(6'b000101); idle(1);
    cur_tag = "R7";  wr(6'b001101); line(4);
    wr(6'b001001); line(3); wr(6'b001011); line(2);
    cur_tag = "R2";  wr(6'b001000); idle(2);
    cur_tag = "R8";  wr(6'b000101); line(1); idle(8);
    line(1); idle(2); line(1); idle(8);
    cur_tag = "R9";  wr(6'b010101); line(1); idle(8);
    cur_tag = "R10"; wr(6'b100101);
    for (int i = 0; i < 6; i++) step(1'b0, '0, 1'b0, 1'b0, i[0]);
    wr(6'b110101);
    for (int i = 0; i < 6; i++) step(1'b0, '0, 1'b0, (i == 2), i[1]);
    idle(3);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule